// File: doc/BRIEF.md
# Flash In-Application Command Gate

This block stands between a processor's register writes and a flash array. It decides whether an in-application flash command may run. Software loads a configuration byte, a data mailbox and a two-byte address. It then writes two key bytes to two key registers and then the command byte. The gate starts a flash operation only when the enable bit is set, the keys arrived in the right order with the right values directly before the command, and the command's own set-up conditions are met. In every other case the command is dropped: a rejection pulse is raised and the completion status reads 0.

While a command runs, the gate holds the processor. It drives a single request to the flash array with an operation code, address and write data, and keeps all three stable until the array acknowledges. It keeps one lock bit per page of the low partition. Read commands aimed at a locked page finish without touching the array, so the data mailbox keeps its previous contents. Program commands aimed at a locked page are rejected.

The controller has five states. IDLE goes to KEY_SEEN on a first-key write of A2h. KEY_SEEN goes to ARMED on a second-key write of DFh. ARMED goes to EXEC when an accepted command needs the array, and to FINISH when an accepted command is handled inside the gate. EXEC goes to FINISH on the array's acknowledge. FINISH returns to IDLE after one cycle. Any other write in IDLE, KEY_SEEN or ARMED returns the controller to IDLE. This includes a wrong key value, a key out of order, a write to another register, and any command write, whether accepted or rejected.

Top module: `flash_cmd_gate`

## Requirements
- R1: A command write is rejected unless bit 6 of the configuration register (select 0) is 1.
- R2: A command write (select 1) is accepted only when it directly follows a write of A2h to key register one (select 5) and then a write of DFh to key register two (select 6). Cycles with no write in between do not matter.
- R3: A wrong key value, keys written in reverse order, or a write to any other register (data select 2, address-low select 3, address-high select 4, configuration) after the keys breaks the unlock, and that command is rejected.
- R4: A rejected command gives a one-cycle `cmd_reject` pulse and `cmd_status` = 0. A command that completes gives a one-cycle `cmd_done` pulse followed by `cmd_status` = 1.
- R5: `cpu_hold` is high from the cycle after acceptance until the command finishes. `fl_req`, `fl_op` and `fl_addr` stay stable until `fl_ack`.
- R6: Only the codes 0Ch (read), 0Eh (program), 0Dh (erase low partition), 06h (lock page) and 08h (clock-double option) are valid; any other code is rejected.
- R7: Erase is accepted only with 55h in the data mailbox. It issues `fl_op` 2. On completion, bytes 0000h–7FFFh read FFh and all page lock bits are 0.
- R8: Lock page sets the lock bit of page address[14:13] when the address is below 8000h. It makes no array access.
- R9: A read of an unlocked address issues `fl_op` 0 and loads the returned byte into the mailbox. A read of a locked page completes without an array access and leaves the mailbox unchanged.
- R10: A program to an unlocked address issues `fl_op` 1 with the mailbox byte as write data. A program to a locked page is rejected.
- R11: Code 08h is accepted only with E0h in the address-high register. It issues `fl_op` 3, and on completion `clk_dbl` becomes 1.
- R12: Register writes made while `cpu_hold` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| iap_enable | output | 1 | Enable bit of the configuration register |
| mbox_data | output | 8 | Data mailbox contents |
| cmd_status | output | 1 | Completion status of the last command |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_reject | output | 1 | One-cycle rejection pulse |
| cpu_hold | output | 1 | Processor hold while a command runs |
| page_locked | output | 4 | Lock bits of the low-partition pages |
| clk_dbl | output | 1 | Clock-double option programmed |
| fl_req | output | 1 | Flash operation request |
| fl_op | output | 2 | Flash operation: 0 read, 1 program, 2 erase, 3 option |
| fl_addr | output | 16 | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_ack | input | 1 | Flash operation acknowledge (one cycle) |
| fl_rdata | input | 8 | Flash read data, valid with acknowledge |

## Verification
The assertions check the following on every cycle:
- the processor is held whenever the array is requested;
- the request and its operands stay still until the acknowledge;
- a hold always begins right after a command write;
- no array request starts without the enable bit;
- the two pulses agree with the status bit;
- an erase acknowledge clears every lock bit.

Some properties depend on the history of writes and on the contents of the array, so only the bench scenarios can show them:
- that a key broken by a stray write rejects the command;
- that a locked read returns the old mailbox byte;
- that a program lands at the right address;
- that writes made during a hold are lost.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

    localparam logic [2:0] SEL_CFG  = 3'd0;
    localparam logic [2:0] SEL_CMD  = 3'd1;
    localparam logic [2:0] SEL_DATA = 3'd2;
    localparam logic [2:0] SEL_ADLO = 3'd3;
    localparam logic [2:0] SEL_ADHI = 3'd4;
    localparam logic [2:0] SEL_KEY1 = 3'd5;
    localparam logic [2:0] SEL_KEY2 = 3'd6;

    localparam logic [7:0] KEY1_VAL    = 8'hA2;
    localparam logic [7:0] KEY2_VAL    = 8'hDF;
    localparam logic [7:0] ERASE_SETUP = 8'h55;
    localparam logic [7:0] CLKDBL_ADHI = 8'hE0;

    localparam logic [7:0] CODE_READ  = 8'h0C;
    localparam logic [7:0] CODE_PROG  = 8'h0E;
    localparam logic [7:0] CODE_ERASE = 8'h0D;
    localparam logic [7:0] CODE_LOCK  = 8'h06;
    localparam logic [7:0] CODE_CLKDB = 8'h08;

    localparam logic [1:0] FOP_READ   = 2'd0;
    localparam logic [1:0] FOP_PROG   = 2'd1;
    localparam logic [1:0] FOP_ERASE  = 2'd2;
    localparam logic [1:0] FOP_OPTION = 2'd3;

    typedef enum logic [1:0] {
        ACT_FLASH,
        ACT_LOCKSET,
        ACT_NOP
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY_SEEN,
        ST_ARMED,
        ST_EXEC,
        ST_FINISH
    } gate_state_e;

endpackage

// File: rtl/fcg_mailbox.sv
module fcg_mailbox
    import fcg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_load,
    input  logic [DATA_W-1:0] rd_value,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] adlo_q,
    output logic [DATA_W-1:0] adhi_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            data_q <= '0;
            adlo_q <= '0;
            adhi_q <= '0;
        end else begin
            if (wr_en && wr_sel == SEL_CFG)  cfg_q  <= wr_data;
            if (wr_en && wr_sel == SEL_ADLO) adlo_q <= wr_data;
            if (wr_en && wr_sel == SEL_ADHI) adhi_q <= wr_data;
            if (rd_load)
                data_q <= rd_value;
            else if (wr_en && wr_sel == SEL_DATA)
                data_q <= wr_data;
        end
    end

endmodule

// File: rtl/fcg_lock_table.sv
module fcg_lock_table #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_CNT  = 4,
    parameter int PAGE_BITS = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                set_en,
    input  logic                clr_all,
    output logic                hit,
    output logic [PAGE_CNT-1:0] locks
);

    localparam int IDX_W = (PAGE_CNT > 1) ? $clog2(PAGE_CNT) : 1;
    localparam logic [ADDR_W:0] PART_END = (ADDR_W+1)'(PAGE_CNT) << PAGE_BITS;

    logic                 in_part;
    logic [IDX_W-1:0]     idx;
    logic [PAGE_CNT-1:0]  page_sel;
    logic [PAGE_CNT-1:0]  locks_q;

    assign in_part = {1'b0, addr} < PART_END;
    assign idx     = addr[PAGE_BITS +: IDX_W];

    for (genvar g = 0; g < PAGE_CNT; g++) begin : g_page
        assign page_sel[g] = in_part && (idx == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            locks_q <= '0;
        else if (clr_all)
            locks_q <= '0;
        else if (set_en)
            locks_q <= locks_q | page_sel;
    end

    assign hit   = |(locks_q & page_sel);
    assign locks = locks_q;

endmodule

// File: rtl/fcg_cmd_decode.sv
module fcg_cmd_decode
    import fcg_pkg::*;
(
    input  logic [7:0] code,
    input  logic [7:0] data,
    input  logic [7:0] adhi,
    input  logic       locked_hit,
    output logic       valid,
    output act_e       act,
    output logic [1:0] fop
);

    always_comb begin
        valid = 1'b0;
        act   = ACT_NOP;
        fop   = FOP_READ;
        case (code)
            CODE_READ: begin
                valid = 1'b1;
                act   = locked_hit ? ACT_NOP : ACT_FLASH;
                fop   = FOP_READ;
            end
            CODE_PROG: begin
                valid = !locked_hit;
                act   = ACT_FLASH;
                fop   = FOP_PROG;
            end
            CODE_ERASE: begin
                valid = (data == ERASE_SETUP);
                act   = ACT_FLASH;
                fop   = FOP_ERASE;
            end
            CODE_LOCK: begin
                valid = 1'b1;
                act   = ACT_LOCKSET;
            end
            CODE_CLKDB: begin
                valid = (adhi == CLKDBL_ADHI);
                act   = ACT_FLASH;
                fop   = FOP_OPTION;
            end
            default: valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
    import fcg_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PAGE_CNT  = 4,
    parameter int PAGE_BITS = 13,
    parameter int EN_BIT    = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [2:0]            reg_sel,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic                  iap_enable,
    output logic [DATA_W-1:0]     mbox_data,
    output logic                  cmd_status,
    output logic                  cmd_done,
    output logic                  cmd_reject,
    output logic                  cpu_hold,
    output logic [PAGE_CNT-1:0]   page_locked,
    output logic                  clk_dbl,
    output logic                  fl_req,
    output logic [1:0]            fl_op,
    output logic [2*DATA_W-1:0]   fl_addr,
    output logic [DATA_W-1:0]     fl_wdata,
    input  logic                  fl_ack,
    input  logic [DATA_W-1:0]     fl_rdata
);

    localparam int ADDR_W = 2 * DATA_W;

    gate_state_e         state_q, state_d;
    logic                busy;
    logic                wr_ok;
    logic                cmd_wr;
    logic                accept;
    logic [DATA_W-1:0]   cfg_q, data_q, adlo_q, adhi_q;
    logic [ADDR_W-1:0]   addr;
    logic                lock_hit;
    logic                dec_valid;
    act_e                dec_act;
    logic [1:0]          dec_fop;
    logic [1:0]          op_q;
    logic                status_q, reject_q, clkdbl_q;
    logic                ack_seen;

    assign busy   = (state_q == ST_EXEC) || (state_q == ST_FINISH);
    assign wr_ok  = reg_we && !busy;
    assign cmd_wr = wr_ok && (reg_sel == SEL_CMD);
    assign accept = cmd_wr && (state_q == ST_ARMED) && cfg_q[EN_BIT] && dec_valid;
    assign ack_seen = (state_q == ST_EXEC) && fl_ack;
    assign addr   = {adhi_q, adlo_q};

    fcg_mailbox #(.DATA_W(DATA_W)) u_mbox (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_sel   (reg_sel),
        .wr_data  (reg_wdata),
        .rd_load  (ack_seen && (op_q == FOP_READ)),
        .rd_value (fl_rdata),
        .cfg_q    (cfg_q),
        .data_q   (data_q),
        .adlo_q   (adlo_q),
        .adhi_q   (adhi_q)
    );

    fcg_lock_table #(
        .ADDR_W   (ADDR_W),
        .PAGE_CNT (PAGE_CNT),
        .PAGE_BITS(PAGE_BITS)
    ) u_locks (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .set_en  (accept && (dec_act == ACT_LOCKSET)),
        .clr_all (ack_seen && (op_q == FOP_ERASE)),
        .hit     (lock_hit),
        .locks   (page_locked)
    );

    fcg_cmd_decode u_dec (
        .code       (reg_wdata[7:0]),
        .data       (data_q[7:0]),
        .adhi       (adhi_q[7:0]),
        .locked_hit (lock_hit),
        .valid      (dec_valid),
        .act        (dec_act),
        .fop        (dec_fop)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_KEY_SEEN, ST_ARMED: begin
                if (wr_ok) begin
                    case (reg_sel)
                        SEL_KEY1: state_d = (reg_wdata == KEY1_VAL) ? ST_KEY_SEEN : ST_IDLE;
                        SEL_KEY2: state_d = (state_q == ST_KEY_SEEN && reg_wdata == KEY2_VAL)
                                            ? ST_ARMED : ST_IDLE;
                        SEL_CMD:  state_d = !accept ? ST_IDLE :
                                            (dec_act == ACT_FLASH) ? ST_EXEC : ST_FINISH;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_EXEC:   if (fl_ack) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= FOP_READ;
            status_q <= 1'b0;
            reject_q <= 1'b0;
            clkdbl_q <= 1'b0;
        end else begin
            reject_q <= cmd_wr && !accept;
            if (accept) begin
                op_q     <= dec_fop;
                status_q <= 1'b0;
            end else if (cmd_wr) begin
                status_q <= 1'b0;
            end else if (state_q == ST_FINISH) begin
                status_q <= 1'b1;
            end
            if (ack_seen && op_q == FOP_OPTION)
                clkdbl_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cpu_hold = busy;
        fl_req   = (state_q == ST_EXEC);
        cmd_done = (state_q == ST_FINISH);
    end

    assign iap_enable = cfg_q[EN_BIT];
    assign mbox_data  = data_q;
    assign cmd_status = status_q;
    assign cmd_reject = reject_q;
    assign clk_dbl    = clkdbl_q;
    assign fl_op      = op_q;
    assign fl_addr    = addr;
    assign fl_wdata   = data_q;

endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
    parameter int ADDR_W   = 16,
    parameter int PAGE_CNT = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [2:0]          reg_sel,
    input logic                iap_enable,
    input logic                cpu_hold,
    input logic                fl_req,
    input logic                fl_ack,
    input logic [1:0]          fl_op,
    input logic [ADDR_W-1:0]   fl_addr,
    input logic                cmd_done,
    input logic                cmd_reject,
    input logic                cmd_status,
    input logic [PAGE_CNT-1:0] page_locked
);

    AST_REQ_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> cpu_hold);  // R5

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_op) && $stable(fl_addr)));  // R5

    AST_HOLD_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_hold) |-> $past(reg_we && reg_sel == 3'd1));  // R2

    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) |-> iap_enable);  // R1

    AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> cmd_status);  // R4

    AST_REJECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> (!cmd_status && !cpu_hold));  // R4

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && cmd_reject));  // R4

    AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_ack && fl_op == 2'd2) |=> (page_locked == '0));  // R7

endmodule

bind flash_cmd_gate fcg_checker #(.ADDR_W(2*DATA_W), .PAGE_CNT(PAGE_CNT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .iap_enable (iap_enable),
    .cpu_hold   (cpu_hold),
    .fl_req     (fl_req),
    .fl_ack     (fl_ack),
    .fl_op      (fl_op),
    .fl_addr    (fl_addr),
    .cmd_done   (cmd_done),
    .cmd_reject (cmd_reject),
    .cmd_status (cmd_status),
    .page_locked(page_locked)
);

// File: tb/sim_flash_cmd_gate.sv
module sim_flash_cmd_gate;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic        iap_enable, cmd_status, cmd_done, cmd_reject, cpu_hold, clk_dbl;
    logic [7:0]  mbox_data, fl_wdata;
    logic [3:0]  page_locked;
    logic        fl_req;
    logic [1:0]  fl_op;
    logic [15:0] fl_addr;
    logic        fl_ack = 1'b0;
    logic [7:0]  fl_rdata = 8'h00;

    int checks = 0, errors = 0;
    int ack_cnt = 0, done_cnt = 0, fcnt = 0;
    bit finished = 0;

    logic [7:0] fmem [0:65535];
    logic [7:0] smem [0:65535];
    logic [3:0] exp_lock = 4'h0;
    logic       exp_clk  = 1'b0;
    logic [7:0] exp_mbox = 8'h00;

    always #4 clk = ~clk;

    flash_cmd_gate u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .iap_enable(iap_enable), .mbox_data(mbox_data),
        .cmd_status(cmd_status), .cmd_done(cmd_done), .cmd_reject(cmd_reject),
        .cpu_hold(cpu_hold), .page_locked(page_locked), .clk_dbl(clk_dbl),
        .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_ack(fl_ack), .fl_rdata(fl_rdata)
    );

    // Behavioural flash array
    always @(posedge clk) begin
        if (!rst_n) begin
            fl_ack <= 1'b0;
            fcnt   <= 0;
        end else if (fl_ack) begin
            fl_ack <= 1'b0;
            fcnt   <= 0;
        end else if (fl_req) begin
            if (fcnt == LAT - 1) begin
                fl_ack  <= 1'b1;
                ack_cnt <= ack_cnt + 1;
                case (fl_op)
                    2'd0: fl_rdata <= fmem[fl_addr];
                    2'd1: fmem[fl_addr] <= fl_wdata;
                    2'd2: for (int i = 0; i < 32768; i++) fmem[i] <= 8'hFF;
                    default: ;
                endcase
            end else begin
                fcnt <= fcnt + 1;
            end
        end
        if (rst_n && cmd_done) done_cnt <= done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic feed();
        wr(3'd5, 8'hA2);
        wr(3'd6, 8'hDF);
    endtask

    function automatic bit is_locked(input logic [15:0] a);
        return (a < 16'h8000) && exp_lock[a[14:13]];
    endfunction

    function automatic bit cmd_valid(input logic [7:0] c, input logic [7:0] d,
                                     input logic [7:0] hi, input bit lk);
        case (c)
            8'h0C: return 1'b1;
            8'h0E: return !lk;
            8'h0D: return d == 8'h55;
            8'h06: return 1'b1;
            8'h08: return hi == 8'hE0;
            default: return 1'b0;
        endcase
    endfunction

    // mode: 0 proper unlock, 1 second key missing, 2 wrong first key,
    //       3 stray register write after keys, 4 keys reversed
    task automatic do_op(input logic [7:0] code, input logic [7:0] dat,
                         input logic [15:0] addr, input bit en, input int mode,
                         input string req, input bit poke);
        bit ok, lk, fl;
        int a0, d0, hc;
        lk = is_locked(addr);
        ok = en && (mode == 0) && cmd_valid(code, dat, addr[15:8], lk);
        fl = ok && (code == 8'h0E || code == 8'h0D || code == 8'h08 ||
                    (code == 8'h0C && !lk));
        wr(3'd0, en ? 8'h40 : 8'h00);
        wr(3'd2, dat);
        wr(3'd3, addr[7:0]);
        wr(3'd4, addr[15:8]);
        exp_mbox = dat;
        case (mode)
            0: feed();
            1: wr(3'd5, 8'hA2);
            2: begin wr(3'd5, 8'hA3); wr(3'd6, 8'hDF); end
            3: begin feed(); wr(3'd3, addr[7:0]); end
            4: begin wr(3'd6, 8'hDF); wr(3'd5, 8'hA2); end
            default: ;
        endcase
        a0 = ack_cnt; d0 = done_cnt;
        wr(3'd1, code);
        if (!ok) begin
            chk(cmd_reject === 1'b1 && cmd_status === 1'b0 && cpu_hold === 1'b0,
                req, "reject/status/hold", {cmd_reject, cmd_status, cpu_hold}, 3'b100);
        end else begin
            chk(cpu_hold === 1'b1, req, "hold after accept", cpu_hold, 1);
            if (poke) wr(3'd2, 8'h11);
            hc = 0;
            while (cpu_hold === 1'b1 && hc < 200) begin
                @(negedge clk);
                hc++;
            end
            if (fl && !poke) chk(hc >= LAT, "R5", "hold length", hc, LAT);
            chk(cmd_status === 1'b1, req, "status after completion", cmd_status, 1);
            case (code)
                8'h0C: if (!lk) exp_mbox = smem[addr];
                8'h0E: smem[addr] = dat;
                8'h0D: begin
                    for (int i = 0; i < 32768; i++) smem[i] = 8'hFF;
                    exp_lock = 4'h0;
                end
                8'h06: if (addr < 16'h8000) exp_lock[addr[14:13]] = 1'b1;
                8'h08: exp_clk = 1'b1;
                default: ;
            endcase
        end
        @(negedge clk);
        chk(ack_cnt - a0 == (fl ? 1 : 0), req, "array accesses", ack_cnt - a0, fl ? 1 : 0);
        chk(done_cnt - d0 == (ok ? 1 : 0), req, "done pulses", done_cnt - d0, ok ? 1 : 0);
        chk(mbox_data === exp_mbox, req, "mailbox", mbox_data, exp_mbox);
        chk(page_locked === exp_lock, req, "lock bits", page_locked, exp_lock);
        chk(clk_dbl === exp_clk, req, "clock double", clk_dbl, exp_clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        for (int i = 0; i < 65536; i++) begin
            fmem[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h3C;
            smem[i] = fmem[i];
        end
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_status === 0 && cpu_hold === 0 && fl_req === 0 && cmd_reject === 0,
            "R4", "reset outputs", {cmd_status, cpu_hold, fl_req, cmd_reject}, 0);
        chk(mbox_data === 8'h00 && page_locked === 4'h0 && clk_dbl === 0,
            "R5", "reset registers", mbox_data, 0);

        do_op(8'h0C, 8'h00, 16'h1234, 1'b0, 0, "R1", 1'b0);   // enable off
        do_op(8'h0C, 8'h00, 16'h1234, 1'b1, 0, "R9", 1'b0);   // unlocked read
        do_op(8'h0C, 8'h00, 16'h1234, 1'b1, 1, "R2", 1'b0);   // second key missing
        do_op(8'h0C, 8'h00, 16'h1234, 1'b1, 2, "R3", 1'b0);   // wrong first key
        do_op(8'h0C, 8'h00, 16'h1234, 1'b1, 3, "R3", 1'b0);   // stray write after keys
        do_op(8'h0C, 8'h00, 16'h1234, 1'b1, 4, "R3", 1'b0);   // keys reversed
        do_op(8'h77, 8'h00, 16'h1234, 1'b1, 0, "R6", 1'b0);   // unknown code
        do_op(8'h0E, 8'h5A, 16'h2345, 1'b1, 0, "R10", 1'b0);  // program unlocked
        do_op(8'h0C, 8'h00, 16'h2345, 1'b1, 0, "R10", 1'b0);  // read it back
        do_op(8'h06, 8'h00, 16'h2345, 1'b1, 0, "R8", 1'b0);   // lock page 1
        do_op(8'h06, 8'h00, 16'h9000, 1'b1, 0, "R8", 1'b0);   // above partition
        do_op(8'h0C, 8'h77, 16'h2345, 1'b1, 0, "R9", 1'b0);   // locked read
        do_op(8'h0E, 8'h33, 16'h2000, 1'b1, 0, "R10", 1'b0);  // locked program
        do_op(8'h0D, 8'h54, 16'h0000, 1'b1, 0, "R7", 1'b0);   // erase without set-up
        do_op(8'h0D, 8'h55, 16'h0000, 1'b1, 0, "R7", 1'b0);   // erase
        do_op(8'h0C, 8'h00, 16'h2345, 1'b1, 0, "R7", 1'b0);   // erased byte
        do_op(8'h08, 8'h00, 16'hE100, 1'b1, 0, "R11", 1'b0);  // wrong high address
        do_op(8'h08, 8'h00, 16'hE000, 1'b1, 0, "R11", 1'b0);  // clock double
        do_op(8'h0E, 8'hC4, 16'h4001, 1'b1, 0, "R12", 1'b1);  // write during hold
        do_op(8'h0C, 8'h00, 16'h4001, 1'b1, 0, "R12", 1'b0);

        for (int n = 0; n < 300; n++) begin
            logic [7:0]  c, d;
            logic [15:0] a;
            int m;
            case ($urandom % 7)
                0, 1: c = 8'h0C;
                2:    c = 8'h0E;
                3:    c = ($urandom % 4 == 0) ? 8'h0D : 8'h0C;
                4:    c = 8'h06;
                5:    c = 8'h08;
                default: c = 8'($urandom);
            endcase
            d = ($urandom % 3 == 0) ? 8'h55 : 8'($urandom);
            a = 16'($urandom);
            if ($urandom % 4 == 0) a[15:8] = 8'hE0;
            m = ($urandom % 5 == 0) ? 1 + int'($urandom % 4) : 0;
            do_op(c, d, a, ($urandom % 8) != 0, m,
                  (m != 0) ? "R3" : (c == 8'h0C) ? "R9" : (c == 8'h0E) ? "R10" :
                  (c == 8'h0D) ? "R7" : (c == 8'h06) ? "R8" : (c == 8'h08) ? "R11" : "R6",
                  1'b0);
        end

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R5 watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

endmodule